// File: doc/BRIEF.md
# Pluggable Transceiver Bring-Up Sequencer

This block brings a pluggable transceiver cage from "empty" to "PHY found" once a module is seated. Each module is identified first, and that step yields a compliance code plus a few class flags. The sequencer samples that identification when it sees the module present. It then releases the transmit-disable line and waits a settle time chosen for that module class. After the settle time it watches the transmit-fault line for what is left of the module's start-up window.

When the fault line drops, the sequencer enables the management path toward the module's internal PHY, provided the module has one, and waits for that path to report ready or error. It then issues PHY probe requests at an address that depends on the management protocol. A failed probe is retried after a short gap.

A fault that persists to the end of the window re-runs initialisation a limited number of times before the sequencer gives up. Pulling the module out at any point returns everything to the idle, transmit-disabled state. All timing is counted in ticks of a millisecond strobe, so the same logic serves any system clock.

Top module: `module_bringup`

## Requirements
- R1: After synchronous reset the state output is DOWN (encoding 0), `tx_disable` is 1, and `mgmt_en`, `probe_req`, `fault`, `failed` are 0.
- R2: In DOWN with `mod_present` high, the next clock enters SETTLE (1) with `tx_disable` 0. The identification inputs are captured on that clock and held until the module is removed.
- R3: SETTLE lasts exactly SETTLE_MS ticks, or SETTLE_SLOW_MS ticks when `id_slow_settle` was captured high. It then enters FAULT_WAIT (2).
- R4: The window is START_MS, or START_LONG_MS when `id_long_start` was captured high. FAULT_WAIT expires after (window − settle) ticks when that value is positive, and after 1 tick otherwise.
- R5: In FAULT_WAIT, `tx_fault` low moves the sequencer on the next clock to MGMT (3) with `mgmt_en` 1, and clears `fault`.
- R6: If FAULT_WAIT expires with `tx_fault` high, `fault` goes to 1 and SETTLE is re-entered, up to INIT_RETRIES times. The next expiry enters FAIL (7) with `failed` 1 and `tx_disable` 1.
- R7: In MGMT, `mgmt_err` enters FAIL. Otherwise `mgmt_ready` enters PROBE (4) with `probe_req` 1 and the probe retry count reset.
- R8: In PROBE, `probe_ok` enters READY (6). `probe_fail` enters GAP (5) for PROBE_GAP_MS ticks and then returns to PROBE. The failure after PROBE_RETRIES retries enters FAIL.
- R9: Protocol output `mgmt_proto` uses the encoding 0 none, 1 Clause 22, 2 Clause 45, 3 mailbox. Mailbox wins if `id_force_mailbox` is set. Otherwise Clause 45 is chosen for extended codes 0x16, 0x1C, 0x1D or 0x1E. Otherwise Clause 22 is chosen if `id_gbase_t` is set. Otherwise the protocol is none.
- R10: `probe_addr` is 22 for Clause 22/45 and 17 for mailbox. With protocol none, fault clearance goes straight to READY with `mgmt_en` and `probe_req` kept 0, and `mgmt_ready` has no effect.
- R11: `mod_present` low in any state gives DOWN on the next clock, with `tx_disable` 1 and `mgmt_en`, `probe_req`, `fault`, `failed` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| mod_present | input | 1 | Module seated in cage |
| tx_fault | input | 1 | Module transmit-fault line |
| id_ext_code | input | 8 | Extended compliance code from identification |
| id_gbase_t | input | 1 | Module reports 1000BASE-T |
| id_force_mailbox | input | 1 | Per-module override forcing mailbox access |
| id_slow_settle | input | 1 | Module class with long settle time |
| id_long_start | input | 1 | Module class with long start-up window |
| mgmt_ready | input | 1 | Management path came up |
| mgmt_err | input | 1 | Management path creation failed |
| probe_ok | input | 1 | PHY probe succeeded |
| probe_fail | input | 1 | PHY probe failed |
| tx_disable | output | 1 | Transmit disable to module |
| mgmt_en | output | 1 | Enable management path |
| probe_req | output | 1 | PHY probe request, held until answered |
| probe_addr | output | 5 | PHY address to probe |
| mgmt_proto | output | 2 | Selected management protocol |
| seq_state | output | 3 | Current sequencer state |
| fault | output | 1 | Start-up window expired with fault asserted |
| failed | output | 1 | Sequencer gave up |

## Verification
The main sequence is driven with four module profiles.

A Clause 45 module with a fault that clears late shows the exact settle and remaining-window tick counts, and it runs through probe retries until they are exhausted. A slow-settle mailbox module whose fault never clears shows the one-tick floor on the window and the re-initialisation limit. A long-window mailbox module with no fault shows immediate progression and the mailbox probe address. A Clause 22 module shows the long window, the clearing of `fault` after a retry, and management failure.

A protocol-none module shows that the management and probe steps are skipped. Removal in the middle of a sequence, and removal after failure, both show the return to idle.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_FWAIT  = 3'd2,
    ST_MGMT   = 3'd3,
    ST_PROBE  = 3'd4,
    ST_GAP    = 3'd5,
    ST_READY  = 3'd6,
    ST_FAIL   = 3'd7
  } seq_state_t;

  typedef enum logic [1:0] {
    PR_NONE = 2'd0,
    PR_C22  = 2'd1,
    PR_C45  = 2'd2,
    PR_MBOX = 2'd3
  } mgmt_proto_t;

  localparam int NUM_BASET_CODES = 4;
endpackage

// File: rtl/mbu_proto_sel.sv
module mbu_proto_sel
  import mbu_pkg::*;
#(
  parameter int AW            = 5,
  parameter int PHY_ADDR_STD  = 22,
  parameter int PHY_ADDR_MBOX = 17
) (
  input  logic [7:0]    ext_code,
  input  logic          gbase_t,
  input  logic          force_mbox,
  output mgmt_proto_t   proto,
  output logic [AW-1:0] addr
);
  localparam logic [7:0] BASET_CODES [NUM_BASET_CODES] = '{8'h16, 8'h1C, 8'h1D, 8'h1E};

  logic [NUM_BASET_CODES-1:0] code_hit;

  // One comparator per copper compliance code
  for (genvar g = 0; g < NUM_BASET_CODES; g++) begin : g_code
    assign code_hit[g] = (ext_code == BASET_CODES[g]);
  end

  always_comb begin
    if (force_mbox)       proto = PR_MBOX;
    else if (|code_hit)   proto = PR_C45;
    else if (gbase_t)     proto = PR_C22;
    else                  proto = PR_NONE;
  end

  always_comb begin
    case (proto)
      PR_MBOX:        addr = AW'(PHY_ADDR_MBOX);
      PR_C22, PR_C45: addr = AW'(PHY_ADDR_STD);
      default:        addr = '0;
    endcase
  end
endmodule

// File: rtl/mbu_window_calc.sv
module mbu_window_calc #(
  parameter int SETTLE_MS      = 50,
  parameter int SETTLE_SLOW_MS = 25000,
  parameter int START_MS       = 300,
  parameter int START_LONG_MS  = 60000,
  parameter int CW             = 16
) (
  input  logic          slow_settle,
  input  logic          long_start,
  output logic [CW-1:0] settle_lim,
  output logic [CW-1:0] wait_lim
);
  int settle_t;
  int window_t;

  always_comb begin
    settle_t   = slow_settle ? SETTLE_SLOW_MS : SETTLE_MS;
    window_t   = long_start  ? START_LONG_MS  : START_MS;
    settle_lim = CW'(settle_t);
    // remaining window after settling, never below one tick
    if (window_t > settle_t) wait_lim = CW'(window_t - settle_t);
    else                     wait_lim = CW'(1);
  end
endmodule

// File: rtl/mbu_tick_timer.sv
module mbu_tick_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // fires on the tick that completes the limit
  assign done = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/mbu_seq_fsm.sv
module mbu_seq_fsm
  import mbu_pkg::*;
#(
  parameter int INIT_RETRIES  = 3,
  parameter int PROBE_RETRIES = 3,
  parameter int PROBE_GAP_MS  = 20,
  parameter int CW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          present,
  input  logic          tx_fault,
  input  logic          mgmt_ready,
  input  logic          mgmt_err,
  input  logic          probe_ok,
  input  logic          probe_fail,
  input  mgmt_proto_t   cfg_proto,
  input  logic [CW-1:0] settle_lim,
  input  logic [CW-1:0] wait_lim,
  input  logic          tmr_done,
  output seq_state_t    st_q,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  output logic          tx_disable,
  output logic          mgmt_en,
  output logic          probe_req,
  output logic          fault,
  output logic          failed
);
  localparam int IRW = $clog2(INIT_RETRIES + 2);
  localparam int PRW = $clog2(PROBE_RETRIES + 2);

  seq_state_t     st_n;
  logic [IRW-1:0] init_q, init_n;
  logic [PRW-1:0] prb_q, prb_n;
  logic           fault_n;

  always_comb begin
    st_n    = st_q;
    init_n  = init_q;
    prb_n   = prb_q;
    fault_n = fault;
    if (!present) begin
      st_n    = ST_DOWN;
      init_n  = '0;
      prb_n   = '0;
      fault_n = 1'b0;
    end else begin
      case (st_q)
        ST_DOWN: begin
          st_n    = ST_SETTLE;
          init_n  = '0;
          fault_n = 1'b0;
        end
        ST_SETTLE: if (tmr_done) st_n = ST_FWAIT;
        ST_FWAIT: begin
          if (!tx_fault) begin
            fault_n = 1'b0;
            st_n    = (cfg_proto == PR_NONE) ? ST_READY : ST_MGMT;
          end else if (tmr_done) begin
            fault_n = 1'b1;
            if (init_q < IRW'(INIT_RETRIES)) begin
              init_n = init_q + 1'b1;
              st_n   = ST_SETTLE;
            end else begin
              st_n = ST_FAIL;
            end
          end
        end
        ST_MGMT: begin
          if (mgmt_err) st_n = ST_FAIL;
          else if (mgmt_ready) begin
            st_n  = ST_PROBE;
            prb_n = '0;
          end
        end
        ST_PROBE: begin
          if (probe_ok) st_n = ST_READY;
          else if (probe_fail) begin
            if (prb_q < PRW'(PROBE_RETRIES)) begin
              prb_n = prb_q + 1'b1;
              st_n  = ST_GAP;
            end else begin
              st_n = ST_FAIL;
            end
          end
        end
        ST_GAP: if (tmr_done) st_n = ST_PROBE;
        default: st_n = st_q;
      endcase
    end
  end

  // timer restarts on every state entry
  assign tmr_clr = (st_n != st_q);

  always_comb begin
    case (st_q)
      ST_SETTLE: tmr_limit = settle_lim;
      ST_FWAIT:  tmr_limit = wait_lim;
      ST_GAP:    tmr_limit = CW'(PROBE_GAP_MS);
      default:   tmr_limit = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_DOWN;
      init_q     <= '0;
      prb_q      <= '0;
      fault      <= 1'b0;
      tx_disable <= 1'b1;
      mgmt_en    <= 1'b0;
      probe_req  <= 1'b0;
      failed     <= 1'b0;
    end else begin
      st_q       <= st_n;
      init_q     <= init_n;
      prb_q      <= prb_n;
      fault      <= fault_n;
      tx_disable <= (st_n == ST_DOWN) || (st_n == ST_FAIL);
      mgmt_en    <= (cfg_proto != PR_NONE) &&
                    (st_n == ST_MGMT || st_n == ST_PROBE ||
                     st_n == ST_GAP  || st_n == ST_READY);
      probe_req  <= (st_n == ST_PROBE);
      failed     <= (st_n == ST_FAIL);
    end
  end
endmodule

// File: rtl/module_bringup.sv
module module_bringup
  import mbu_pkg::*;
#(
  parameter int SETTLE_MS      = 50,
  parameter int SETTLE_SLOW_MS = 25000,
  parameter int START_MS       = 300,
  parameter int START_LONG_MS  = 60000,
  parameter int INIT_RETRIES   = 3,
  parameter int PROBE_RETRIES  = 3,
  parameter int PROBE_GAP_MS   = 20,
  parameter int PHY_ADDR_STD   = 22,
  parameter int PHY_ADDR_MBOX  = 17,
  parameter int ADDR_W         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              mod_present,
  input  logic              tx_fault,
  input  logic [7:0]        id_ext_code,
  input  logic              id_gbase_t,
  input  logic              id_force_mailbox,
  input  logic              id_slow_settle,
  input  logic              id_long_start,
  input  logic              mgmt_ready,
  input  logic              mgmt_err,
  input  logic              probe_ok,
  input  logic              probe_fail,
  output logic              tx_disable,
  output logic              mgmt_en,
  output logic              probe_req,
  output logic [ADDR_W-1:0] probe_addr,
  output logic [1:0]        mgmt_proto,
  output logic [2:0]        seq_state,
  output logic              fault,
  output logic              failed
);
  localparam int MAX_A = (SETTLE_SLOW_MS > START_LONG_MS) ? SETTLE_SLOW_MS : START_LONG_MS;
  localparam int MAX_B = (SETTLE_MS > START_MS) ? SETTLE_MS : START_MS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L = (MAX_C > PROBE_GAP_MS) ? MAX_C : PROBE_GAP_MS;
  localparam int CW    = $clog2(MAX_L + 1) + 1;

  mgmt_proto_t       sel_proto, cfg_proto;
  logic [ADDR_W-1:0] sel_addr, cfg_addr;
  logic [CW-1:0]     calc_settle, calc_wait, cfg_settle, cfg_wait;
  logic [CW-1:0]     tmr_limit;
  logic              tmr_clr, tmr_done;
  seq_state_t        st;

  mbu_proto_sel #(
    .AW(ADDR_W), .PHY_ADDR_STD(PHY_ADDR_STD), .PHY_ADDR_MBOX(PHY_ADDR_MBOX)
  ) u_sel (
    .ext_code(id_ext_code), .gbase_t(id_gbase_t), .force_mbox(id_force_mailbox),
    .proto(sel_proto), .addr(sel_addr)
  );

  mbu_window_calc #(
    .SETTLE_MS(SETTLE_MS), .SETTLE_SLOW_MS(SETTLE_SLOW_MS),
    .START_MS(START_MS), .START_LONG_MS(START_LONG_MS), .CW(CW)
  ) u_win (
    .slow_settle(id_slow_settle), .long_start(id_long_start),
    .settle_lim(calc_settle), .wait_lim(calc_wait)
  );

  // identification is captured while idle, frozen during the sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_proto  <= PR_NONE;
      cfg_addr   <= '0;
      cfg_settle <= CW'(1);
      cfg_wait   <= CW'(1);
    end else if (st == ST_DOWN) begin
      cfg_proto  <= sel_proto;
      cfg_addr   <= sel_addr;
      cfg_settle <= calc_settle;
      cfg_wait   <= calc_wait;
    end
  end

  mbu_tick_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick_ms),
    .limit(tmr_limit), .done(tmr_done)
  );

  mbu_seq_fsm #(
    .INIT_RETRIES(INIT_RETRIES), .PROBE_RETRIES(PROBE_RETRIES),
    .PROBE_GAP_MS(PROBE_GAP_MS), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .present(mod_present), .tx_fault(tx_fault),
    .mgmt_ready(mgmt_ready), .mgmt_err(mgmt_err),
    .probe_ok(probe_ok), .probe_fail(probe_fail),
    .cfg_proto(cfg_proto), .settle_lim(cfg_settle), .wait_lim(cfg_wait),
    .tmr_done(tmr_done), .st_q(st), .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
    .tx_disable(tx_disable), .mgmt_en(mgmt_en), .probe_req(probe_req),
    .fault(fault), .failed(failed)
  );

  assign seq_state  = st;
  assign mgmt_proto = cfg_proto;
  assign probe_addr = cfg_addr;
endmodule

// File: rtl/mbu_checker.sv
module mbu_checker
  import mbu_pkg::*;
#(
  parameter int AW            = 5,
  parameter int STD_ADDR      = 22,
  parameter int MBOX_ADDR     = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          mod_present,
  input logic          tx_disable,
  input logic          mgmt_en,
  input logic          probe_req,
  input logic [AW-1:0] probe_addr,
  input logic [1:0]    mgmt_proto,
  input logic [2:0]    seq_state,
  input logic          failed
);
  a_r11_remove_down: assert property (@(posedge clk) disable iff (rst)
    !mod_present |=> (seq_state == ST_DOWN && tx_disable && !mgmt_en && !probe_req));

  a_r5_mgmt_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(mgmt_en) |-> ($past(seq_state) == ST_FWAIT));

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (failed && mod_present) |=> failed);

  a_r8_probe_needs_mgmt: assert property (@(posedge clk) disable iff (rst)
    probe_req |-> mgmt_en);

  a_r10_mbox_addr: assert property (@(posedge clk) disable iff (rst)
    (probe_req && mgmt_proto == PR_MBOX) |-> (probe_addr == AW'(MBOX_ADDR)));

  a_r10_std_addr: assert property (@(posedge clk) disable iff (rst)
    (probe_req && (mgmt_proto == PR_C22 || mgmt_proto == PR_C45)) |-> (probe_addr == AW'(STD_ADDR)));

  a_r10_none_quiet: assert property (@(posedge clk) disable iff (rst)
    (mgmt_proto == PR_NONE) |-> (!mgmt_en && !probe_req));
endmodule

bind module_bringup mbu_checker #(
  .AW(ADDR_W), .STD_ADDR(PHY_ADDR_STD), .MBOX_ADDR(PHY_ADDR_MBOX)
) u_chk (
  .clk(clk), .rst(rst), .mod_present(mod_present), .tx_disable(tx_disable),
  .mgmt_en(mgmt_en), .probe_req(probe_req), .probe_addr(probe_addr),
  .mgmt_proto(mgmt_proto), .seq_state(seq_state), .failed(failed)
);

// File: tb/module_bringup_bench.sv
module module_bringup_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 0, mod_present = 0, tx_fault = 0;
  logic [7:0] id_ext_code = 8'h00;
  logic       id_gbase_t = 0, id_force_mailbox = 0, id_slow_settle = 0, id_long_start = 0;
  logic       mgmt_ready = 0, mgmt_err = 0, probe_ok = 0, probe_fail = 0;
  logic       tx_disable, mgmt_en, probe_req, fault, failed;
  logic [4:0] probe_addr;
  logic [1:0] mgmt_proto;
  logic [2:0] seq_state;

  always #5 clk = ~clk;

  module_bringup #(
    .SETTLE_MS(4), .SETTLE_SLOW_MS(20), .START_MS(10), .START_LONG_MS(30),
    .INIT_RETRIES(1), .PROBE_RETRIES(2), .PROBE_GAP_MS(2)
  ) u_module_bringup (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .mod_present(mod_present),
    .tx_fault(tx_fault), .id_ext_code(id_ext_code), .id_gbase_t(id_gbase_t),
    .id_force_mailbox(id_force_mailbox), .id_slow_settle(id_slow_settle),
    .id_long_start(id_long_start), .mgmt_ready(mgmt_ready), .mgmt_err(mgmt_err),
    .probe_ok(probe_ok), .probe_fail(probe_fail), .tx_disable(tx_disable),
    .mgmt_en(mgmt_en), .probe_req(probe_req), .probe_addr(probe_addr),
    .mgmt_proto(mgmt_proto), .seq_state(seq_state), .fault(fault), .failed(failed)
  );

  typedef struct {
    string       req;
    logic [14:0] val;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  function automatic logic [14:0] obs();
    return {seq_state, tx_disable, mgmt_en, probe_req, probe_addr, mgmt_proto, fault, failed};
  endfunction

  // monitor: compares queued expectations half a cycle after the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (obs() !== e.val) begin
        n_bad++;
        $display("FAIL %s: actual {st,txd,men,preq,addr,proto,flt,fl}=%b_%b%b%b_%0d_%0d_%b%b expected %b_%b%b%b_%0d_%0d_%b%b",
          e.req, obs()[14:12], obs()[11], obs()[10], obs()[9], obs()[8:4], obs()[3:2], obs()[1], obs()[0],
          e.val[14:12], e.val[11], e.val[10], e.val[9], e.val[8:4], e.val[3:2], e.val[1], e.val[0]);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic exp(string req, int st, bit txd, bit men, bit preq, int addr, int pr, bit flt, bit fl);
    exp_t e;
    e.req = req;
    e.val = {st[2:0], txd, men, preq, addr[4:0], pr[1:0], flt, fl};
    q.push_back(e);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      if (i != 0) cyc();
      tick_ms = 1'b1;
      cyc();
      tick_ms = 1'b0;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc();
    sig = 1'b0;
  endtask

  task automatic set_id(logic [7:0] code, bit gt, bit mb, bit slow, bit lng);
    id_ext_code = code; id_gbase_t = gt; id_force_mailbox = mb;
    id_slow_settle = slow; id_long_start = lng;
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    exp("R1 reset state", 0, 1, 0, 0, 0, 0, 0, 0);
    cyc();

    // Clause 45 module, default timing, fault clears late, probe retries run out
    set_id(8'h16, 0, 0, 0, 0);
    tx_fault = 1'b1;
    mod_present = 1'b1;
    cyc();
    exp("R2 R9 insert c45", 1, 0, 0, 0, 22, 2, 0, 0);
    ticks(3);
    exp("R3 settle not done", 1, 0, 0, 0, 22, 2, 0, 0);
    ticks(1);
    exp("R3 settle done", 2, 0, 0, 0, 22, 2, 0, 0);
    ticks(5);
    exp("R4 window remaining", 2, 0, 0, 0, 22, 2, 0, 0);
    tx_fault = 1'b0;
    cyc();
    exp("R5 fault cleared", 3, 0, 1, 0, 22, 2, 0, 0);
    pulse(mgmt_ready);
    exp("R7 mgmt ready", 4, 0, 1, 1, 22, 2, 0, 0);
    pulse(probe_fail);
    exp("R8 first probe fail", 5, 0, 1, 0, 22, 2, 0, 0);
    ticks(1);
    exp("R8 gap running", 5, 0, 1, 0, 22, 2, 0, 0);
    ticks(1);
    exp("R8 gap over", 4, 0, 1, 1, 22, 2, 0, 0);
    pulse(probe_fail);
    ticks(2);
    exp("R8 second retry", 4, 0, 1, 1, 22, 2, 0, 0);
    pulse(probe_fail);
    exp("R8 retries exhausted", 7, 1, 0, 0, 22, 2, 0, 1);
    mod_present = 1'b0;
    cyc();
    exp("R11 removal after fail", 0, 1, 0, 0, 22, 2, 0, 0);
    cyc();

    // mailbox, slow settle longer than window: floor of one tick, init retry limit
    set_id(8'h00, 0, 1, 1, 0);
    tx_fault = 1'b1;
    mod_present = 1'b1;
    cyc();
    exp("R9 insert mailbox", 1, 0, 0, 0, 17, 3, 0, 0);
    ticks(19);
    exp("R3 slow settle not done", 1, 0, 0, 0, 17, 3, 0, 0);
    ticks(1);
    exp("R3 slow settle done", 2, 0, 0, 0, 17, 3, 0, 0);
    ticks(1);
    exp("R4 R6 floor expiry retry", 1, 0, 0, 0, 17, 3, 1, 0);
    ticks(20);
    ticks(1);
    exp("R6 retry limit fail", 7, 1, 0, 0, 17, 3, 1, 1);
    mod_present = 1'b0;
    cyc();
    exp("R11 removal clears fault", 0, 1, 0, 0, 17, 3, 0, 0);
    cyc();

    // mailbox, long window, no fault: probe address 17, success
    set_id(8'h00, 0, 1, 0, 1);
    tx_fault = 1'b0;
    mod_present = 1'b1;
    cyc();
    ticks(4);
    exp("R3 settle to wait", 2, 0, 0, 0, 17, 3, 0, 0);
    cyc();
    exp("R5 no fault immediate", 3, 0, 1, 0, 17, 3, 0, 0);
    pulse(mgmt_ready);
    exp("R10 mailbox probe addr", 4, 0, 1, 1, 17, 3, 0, 0);
    pulse(probe_ok);
    exp("R8 probe ok ready", 6, 0, 1, 0, 17, 3, 0, 0);
    mod_present = 1'b0;
    cyc();
    exp("R11 removal from ready", 0, 1, 0, 0, 17, 3, 0, 0);
    cyc();

    // Clause 22, long window (30-4=26), one retry then clear, mgmt error
    set_id(8'h00, 1, 0, 0, 1);
    tx_fault = 1'b1;
    mod_present = 1'b1;
    cyc();
    exp("R9 insert c22", 1, 0, 0, 0, 22, 1, 0, 0);
    ticks(4);
    ticks(25);
    exp("R4 long window open", 2, 0, 0, 0, 22, 1, 0, 0);
    ticks(1);
    exp("R4 R6 long window expiry", 1, 0, 0, 0, 22, 1, 1, 0);
    tx_fault = 1'b0;
    ticks(4);
    exp("R6 fault held", 2, 0, 0, 0, 22, 1, 1, 0);
    cyc();
    exp("R5 fault flag cleared", 3, 0, 1, 0, 22, 1, 0, 0);
    pulse(mgmt_err);
    exp("R7 mgmt error fail", 7, 1, 0, 0, 22, 1, 0, 1);
    mod_present = 1'b0;
    cyc();
    cyc();

    // protocol none: skip management entirely
    set_id(8'h00, 0, 0, 0, 0);
    mod_present = 1'b1;
    cyc();
    exp("R9 insert none", 1, 0, 0, 0, 0, 0, 0, 0);
    ticks(4);
    cyc();
    exp("R10 none to ready", 6, 0, 0, 0, 0, 0, 0, 0);
    pulse(mgmt_ready);
    exp("R10 none ignores mgmt ready", 6, 0, 0, 0, 0, 0, 0, 0);
    mod_present = 1'b0;
    cyc();
    cyc();

    // code 0x1E, removal in mid-settle
    set_id(8'h1E, 0, 0, 0, 0);
    mod_present = 1'b1;
    cyc();
    exp("R9 code 1E c45", 1, 0, 0, 0, 22, 2, 0, 0);
    ticks(2);
    mod_present = 1'b0;
    cyc();
    exp("R11 removal in settle", 0, 1, 0, 0, 22, 2, 0, 0);
    cyc();
    cyc();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule